// File: doc/BRIEF.md
# Full-Bridge Dead-Time Sequencer

This block drives the four gate enables of a full bridge: one high-side and one low-side switch per leg, on legs A and B. A digital up/down counter stands in for an oscillator timing ramp. The counter climbs to an upper code, then falls to a lower code, and keeps repeating. Each arrival at a threshold ends the conducting diagonal. The block then waits a programmable dead time with every gate off, and after that turns on the other diagonal. Diagonal A is the low side of leg A together with the high side of leg B. Diagonal B is the high side of leg A together with the low side of leg B.

A new run always starts from code zero. Both low sides stay on until the ramp first reaches the lower code, which lets the high-side bootstrap supplies charge before the first high-side pulse.

Two supply flags give under-voltage lockout with hysteresis: one flag marks the turn-on level and the other marks the turn-off level. A trip input latches a fault that only a full supply cycle clears. A hold input stands in for the timing pin being pulled to ground: it stops the oscillation without latching. Dead time, ramp thresholds and counter width are parameters. The dead time must be shorter than the span between the two thresholds.

Top module: `bridge_sequencer`

## Requirements
- R1: After reset, and while in lockout, all four gates are low. Lockout is left only in a cycle where supplyAboveOn is 1 and supplyBelowOff is 0. While in lockout, rampHold and tripIn are ignored unless that exit condition holds, so a later exit starts a normal run.
- R2: While running, the run continues as long as supplyBelowOff is 0, even if supplyAboveOn drops (hysteresis). When supplyBelowOff is 1, all gates are low from the next cycle and the block is back in lockout.
- R3: On leaving lockout the ramp restarts from zero. The output pattern {gateHighA,gateHighB,gateLowA,gateLowB} is 4'b0011 for exactly LOWER_TH cycles. It is then 4'b0000 for one dead time, and then diagonal A, 4'b0110, turns on.
- R4: Diagonal A lasts UPPER_TH-LOWER_TH-dead cycles, until the ramp reaches UPPER_TH. Then all gates are off for one dead time, and then diagonal B, 4'b1001, turns on. The two diagonals never follow each other without a gap.
- R5: Diagonal B lasts UPPER_TH-LOWER_TH-dead cycles, until the falling ramp reaches LOWER_TH. Then all gates are off for one dead time and diagonal A turns on again. The full period is 2*(UPPER_TH-LOWER_TH) cycles.
- R6: The dead time is DEAD_LONG cycles when deadSel is 0 and DEAD_SHORT cycles when deadSel is 1. deadSel is sampled when each dead interval starts.
- R7: While rampHold is 1 in a running state, both high sides are low from the next cycle, both low sides are high, and the ramp is held at zero. After H hold cycles and release, the pattern 4'b0011 lasts H+LOWER_TH-1 cycles in total. It is followed by a dead time and diagonal A.
- R8: tripIn set to 1 makes all gates low from the next cycle and latches a fault. The fault ignores supplyAboveOn, rampHold and the release of tripIn. Only supplyBelowOff, followed by a new lockout exit, restarts the bridge.
- R9: In the same cycle, supplyBelowOff takes precedence over tripIn, and tripIn takes precedence over rampHold. tripIn with rampHold yields 4'b0000, not 4'b0011.
- R10: gateHighA and gateLowA are never both high, and neither are gateHighB and gateLowB. All four gates come straight from flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supplyAboveOn | input | 1 | Supply is above the turn-on level |
| supplyBelowOff | input | 1 | Supply is below the turn-off level |
| tripIn | input | 1 | Latched shutdown request |
| rampHold | input | 1 | Timing ramp forced to ground (non-latched stop) |
| deadSel | input | 1 | 0 selects DEAD_LONG, 1 selects DEAD_SHORT |
| gateHighA | output | 1 | High-side enable, leg A |
| gateHighB | output | 1 | High-side enable, leg B |
| gateLowA | output | 1 | Low-side enable, leg A |
| gateLowB | output | 1 | Low-side enable, leg B |

## Verification
The assertions check these properties on every cycle:
- the two gates of one leg are never on together;
- supplyBelowOff or tripIn darkens all four gates one cycle later;
- a hold turns both high sides off;
- one diagonal never changes directly into the other, and the precharge pattern leaves only through all-off.

Only the bench scenarios can show exact run lengths: the precharge, each dead time under both selections, the diagonal widths, and the stretched precharge after a hold. The same applies to the latched fault surviving input changes and to the precedence of trip over hold.

// File: rtl/bridge_seq_pkg.sv
`timescale 1ns/1ps
package bridge_seq_pkg;
  typedef enum logic [2:0] {
    ST_LOCK, ST_PRE, ST_DEAD, ST_PAIR_A, ST_PAIR_B, ST_FAULT
  } seq_state_t;

  typedef enum logic [1:0] {GATE_OFF, GATE_PRE, GATE_A, GATE_B} gate_sel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      rampClear;
    logic      rampRun;
    logic      deadLoad;
    gate_sel_t gateSel;
  } seq_cmd_t;

  // status from datapath to control
  typedef struct packed {
    logic atLower;
    logic atUpper;
    logic deadDone;
  } ramp_stat_t;
endpackage

// File: rtl/bridge_seq_dp.sv
`timescale 1ns/1ps
module bridge_seq_dp
  import bridge_seq_pkg::*;
#(
  parameter int RAMP_W     = 8,
  parameter int LOWER_TH   = 20,
  parameter int UPPER_TH   = 40,
  parameter int DEAD_LONG  = 8,
  parameter int DEAD_SHORT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       deadSel,
  input  seq_cmd_t   cmd,
  output ramp_stat_t stat,
  output logic [3:0] gateVec
);
  localparam int DEAD_MAX = (DEAD_LONG > DEAD_SHORT) ? DEAD_LONG : DEAD_SHORT;
  localparam int DEAD_W   = $clog2(DEAD_MAX + 1);
  localparam logic [RAMP_W-1:0] LOWER_C = RAMP_W'(LOWER_TH);
  localparam logic [RAMP_W-1:0] UPPER_C = RAMP_W'(UPPER_TH);
  localparam logic [DEAD_W-1:0] LOAD_LONG  = DEAD_W'(DEAD_LONG - 1);
  localparam logic [DEAD_W-1:0] LOAD_SHORT = DEAD_W'(DEAD_SHORT - 1);

  logic [RAMP_W-1:0] rampCnt, rampNext;
  logic              rising;
  logic [DEAD_W-1:0] deadCnt;
  logic [3:0]        gateDec;

  assign rampNext = rising ? rampCnt + RAMP_W'(1) : rampCnt - RAMP_W'(1);

  assign stat.atLower  = (rampNext == LOWER_C);
  assign stat.atUpper  = rising && (rampNext == UPPER_C);
  assign stat.deadDone = (deadCnt == '0);

  // ramp counter with direction flip at each threshold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rampCnt <= '0;
      rising  <= 1'b1;
    end else if (cmd.rampClear) begin
      rampCnt <= '0;
      rising  <= 1'b1;
    end else if (cmd.rampRun) begin
      rampCnt <= rampNext;
      if (rising && rampNext == UPPER_C)       rising <= 1'b0;
      else if (!rising && rampNext == LOWER_C) rising <= 1'b1;
    end
  end

  // dead-time down-counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                deadCnt <= '0;
    else if (cmd.deadLoad)     deadCnt <= deadSel ? LOAD_SHORT : LOAD_LONG;
    else if (deadCnt != '0)    deadCnt <= deadCnt - DEAD_W'(1);
  end

  // gate pattern {highA, highB, lowA, lowB}
  always_comb begin
    unique case (cmd.gateSel)
      GATE_PRE: gateDec = 4'b0011;
      GATE_A:   gateDec = 4'b0110;
      GATE_B:   gateDec = 4'b1001;
      default:  gateDec = 4'b0000;
    endcase
  end

  for (genvar g = 0; g < 4; g++) begin : g_gate_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gateVec[g] <= 1'b0;
      else        gateVec[g] <= gateDec[g];
    end
  end
endmodule

// File: rtl/bridge_seq_ctrl.sv
`timescale 1ns/1ps
module bridge_seq_ctrl
  import bridge_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supplyAboveOn,
  input  logic       supplyBelowOff,
  input  logic       tripIn,
  input  logic       rampHold,
  input  ramp_stat_t stat,
  output seq_cmd_t   cmd
);
  seq_state_t state, stateNext;
  logic       pendB, pendBNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_LOCK;
      pendB <= 1'b0;
    end else begin
      state <= stateNext;
      pendB <= pendBNext;
    end
  end

  always_comb begin
    stateNext     = state;
    pendBNext     = pendB;
    cmd.rampClear = 1'b0;
    cmd.rampRun   = 1'b0;
    cmd.deadLoad  = 1'b0;
    unique case (state)
      ST_LOCK: begin
        if (supplyAboveOn && !supplyBelowOff) begin
          stateNext     = tripIn ? ST_FAULT : ST_PRE;
          cmd.rampClear = 1'b1;
        end
      end
      ST_FAULT: begin
        if (supplyBelowOff) stateNext = ST_LOCK;
      end
      default: begin
        if (supplyBelowOff) begin
          stateNext = ST_LOCK;
        end else if (tripIn) begin
          stateNext = ST_FAULT;
        end else if (rampHold) begin
          stateNext     = ST_PRE;
          cmd.rampClear = 1'b1;
        end else begin
          cmd.rampRun = 1'b1;
          unique case (state)
            ST_PRE: if (stat.atLower) begin
              stateNext = ST_DEAD; cmd.deadLoad = 1'b1; pendBNext = 1'b0;
            end
            ST_DEAD: if (stat.deadDone) begin
              stateNext = pendB ? ST_PAIR_B : ST_PAIR_A;
            end
            ST_PAIR_A: if (stat.atUpper) begin
              stateNext = ST_DEAD; cmd.deadLoad = 1'b1; pendBNext = 1'b1;
            end
            ST_PAIR_B: if (stat.atLower) begin
              stateNext = ST_DEAD; cmd.deadLoad = 1'b1; pendBNext = 1'b0;
            end
            default: stateNext = ST_LOCK;
          endcase
        end
      end
    endcase
    unique case (stateNext)
      ST_PRE:    cmd.gateSel = GATE_PRE;
      ST_PAIR_A: cmd.gateSel = GATE_A;
      ST_PAIR_B: cmd.gateSel = GATE_B;
      default:   cmd.gateSel = GATE_OFF;
    endcase
  end
endmodule

// File: rtl/bridge_sequencer.sv
`timescale 1ns/1ps
module bridge_sequencer
  import bridge_seq_pkg::*;
#(
  parameter int RAMP_W     = 8,
  parameter int LOWER_TH   = 20,
  parameter int UPPER_TH   = 40,
  parameter int DEAD_LONG  = 8,
  parameter int DEAD_SHORT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supplyAboveOn,
  input  logic supplyBelowOff,
  input  logic tripIn,
  input  logic rampHold,
  input  logic deadSel,
  output logic gateHighA,
  output logic gateHighB,
  output logic gateLowA,
  output logic gateLowB
);
  seq_cmd_t   cmd;
  ramp_stat_t stat;
  logic [3:0] gateVec;

  bridge_seq_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .supplyAboveOn(supplyAboveOn), .supplyBelowOff(supplyBelowOff),
    .tripIn(tripIn), .rampHold(rampHold),
    .stat(stat), .cmd(cmd)
  );

  bridge_seq_dp #(
    .RAMP_W(RAMP_W), .LOWER_TH(LOWER_TH), .UPPER_TH(UPPER_TH),
    .DEAD_LONG(DEAD_LONG), .DEAD_SHORT(DEAD_SHORT)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .deadSel(deadSel),
    .cmd(cmd), .stat(stat), .gateVec(gateVec)
  );

  assign {gateHighA, gateHighB, gateLowA, gateLowB} = gateVec;
endmodule

// File: rtl/bridge_sequencer_chk.sv
`timescale 1ns/1ps
module bridge_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic supplyBelowOff,
  input logic tripIn,
  input logic rampHold,
  input logic gateHighA,
  input logic gateHighB,
  input logic gateLowA,
  input logic gateLowB
);
  logic [3:0] pat;
  assign pat = {gateHighA, gateHighB, gateLowA, gateLowB};

  // R10
  leg_a_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateHighA && gateLowA));
  // R10
  leg_b_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateHighB && gateLowB));
  // R2
  lockout_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supplyBelowOff |=> (pat == 4'b0000));
  // R8
  trip_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tripIn |=> (pat == 4'b0000));
  // R7
  hold_high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rampHold |=> (!gateHighA && !gateHighB));
  // R4
  pair_a_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat == 4'b0110) |=> (pat != 4'b1001));
  // R5
  pair_b_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat == 4'b1001) |=> (pat != 4'b0110));
  // R3
  pre_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat == 4'b0011) |=> (pat == 4'b0011 || pat == 4'b0000));
endmodule

bind bridge_sequencer bridge_sequencer_chk i_bridge_sequencer_chk (
  .clk(clk), .rst_n(rst_n), .supplyBelowOff(supplyBelowOff),
  .tripIn(tripIn), .rampHold(rampHold),
  .gateHighA(gateHighA), .gateHighB(gateHighB),
  .gateLowA(gateLowA), .gateLowB(gateLowB)
);

// File: tb/test_bridge_sequencer.sv
`timescale 1ns/1ps
module test_bridge_sequencer;
  localparam int LOW = 20, UP = 40, DL = 8, DS = 4;

  logic clk = 1'b0;
  logic rst_n, supplyAboveOn, supplyBelowOff, tripIn, rampHold, deadSel;
  logic gateHighA, gateHighB, gateLowA, gateLowB;

  always #2.5 clk = ~clk;

  bridge_sequencer #(.RAMP_W(8), .LOWER_TH(LOW), .UPPER_TH(UP),
                     .DEAD_LONG(DL), .DEAD_SHORT(DS)) i_bridge_sequencer (
    .clk(clk), .rst_n(rst_n), .supplyAboveOn(supplyAboveOn),
    .supplyBelowOff(supplyBelowOff), .tripIn(tripIn), .rampHold(rampHold),
    .deadSel(deadSel), .gateHighA(gateHighA), .gateHighB(gateHighB),
    .gateLowA(gateLowA), .gateLowB(gateLowB)
  );

  typedef struct { logic [3:0] pat; int len; string tag; } run_t;
  run_t expQ[$];
  int checks = 0, fails = 0, legBad = 0, runLen = 0;
  bit monOn = 0, haveRun = 0, done = 0;
  logic [3:0] curPat = 4'b0000;

  function automatic logic [3:0] patNow();
    return {gateHighA, gateHighB, gateLowA, gateLowB};
  endfunction

  // len 0 means the run length is not checked
  task automatic expectRun(input logic [3:0] p, input int n, input string tag);
    run_t it;
    it.pat = p; it.len = n; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic checkNow(input logic [3:0] exp, input string tag);
    checks++;
    if (patNow() !== exp) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b", tag, patNow(), exp);
    end
  endtask

  task automatic closeRun();
    run_t it;
    checks++;
    if (expQ.size() == 0) begin
      fails++;
      $display("FAIL R3: run %b len %0d, expected no further run", curPat, runLen);
    end else begin
      it = expQ.pop_front();
      if (it.pat !== curPat || (it.len != 0 && it.len != runLen)) begin
        fails++;
        $display("FAIL %s: run %b len %0d, expected %b len %0d",
                 it.tag, curPat, runLen, it.pat, it.len);
      end
    end
  endtask

  // monitor: compares each completed run of a constant pattern
  always @(negedge clk) begin
    logic [3:0] p;
    if (monOn) begin
      p = patNow();
      if ((p[3] && p[1]) || (p[2] && p[0])) legBad++;
      if (haveRun && p == curPat) runLen++;
      else begin
        if (haveRun) closeRun();
        curPat = p; runLen = 1; haveRun = 1;
      end
    end
  end

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1: watchdog expired, outputs %b expected finished run", patNow());
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; supplyAboveOn = 0; supplyBelowOff = 0;
    tripIn = 0; rampHold = 0; deadSel = 0;
    waitEdges(5);
    rst_n = 1;
    monOn = 1;
    waitEdges(1);
    checkNow(4'b0000, "R1 reset");

    // Scenario 1: lockout ignores trip and hold, long dead time, hysteresis
    expectRun(4'b0000, 0, "R1");
    expectRun(4'b0011, LOW, "R3");
    expectRun(4'b0000, DL, "R6");
    expectRun(4'b0110, UP-LOW-DL, "R3");
    expectRun(4'b0000, DL, "R4");
    expectRun(4'b1001, UP-LOW-DL, "R4");
    expectRun(4'b0000, DL, "R5");
    expectRun(4'b0110, UP-LOW-DL, "R5");
    expectRun(4'b0000, DL, "R4");
    expectRun(4'b1001, UP-LOW-DL, "R5");
    expectRun(4'b0000, DL, "R5");
    expectRun(4'b0110, 0, "R2");
    tripIn = 1; rampHold = 1;
    waitEdges(3);
    checkNow(4'b0000, "R1 lockout");
    tripIn = 0; rampHold = 0;
    waitEdges(2);
    supplyAboveOn = 1;
    waitEdges(30);
    supplyAboveOn = 0;                // supply between the two levels
    waitEdges(81);
    supplyBelowOff = 1;
    waitEdges(2);
    checkNow(4'b0000, "R2 lockout entry");

    // Scenario 2: short dead time, then latched fault
    expectRun(4'b0000, 0, "R2");
    expectRun(4'b0011, LOW, "R3");
    expectRun(4'b0000, DS, "R6");
    expectRun(4'b0110, UP-LOW-DS, "R6");
    expectRun(4'b0000, DS, "R6");
    expectRun(4'b1001, 0, "R8");
    supplyBelowOff = 0; deadSel = 1;
    waitEdges(2);
    supplyAboveOn = 1;
    waitEdges(50);
    tripIn = 1;
    waitEdges(3);
    tripIn = 0;
    waitEdges(10);
    checkNow(4'b0000, "R8 fault after trip release");
    rampHold = 1;
    waitEdges(5);
    rampHold = 0;
    waitEdges(5);
    checkNow(4'b0000, "R8 fault ignores hold");

    // Scenario 3: restart after supply cycle, hold, trip beats hold
    expectRun(4'b0000, 0, "R8");
    expectRun(4'b0011, LOW, "R8");
    expectRun(4'b0000, DS, "R6");
    expectRun(4'b0110, UP-LOW-DS, "R3");
    expectRun(4'b0000, DS, "R4");
    expectRun(4'b1001, 0, "R7");
    expectRun(4'b0011, 10+LOW-1, "R7");
    expectRun(4'b0000, DS, "R7");
    expectRun(4'b0110, UP-LOW-DS, "R7");
    expectRun(4'b0000, DS, "R4");
    expectRun(4'b1001, 0, "R9");
    expectRun(4'b0000, 0, "R9");
    supplyAboveOn = 0; supplyBelowOff = 1;
    waitEdges(3);
    supplyBelowOff = 0; supplyAboveOn = 1;
    waitEdges(50);
    rampHold = 1;
    waitEdges(10);
    rampHold = 0;
    waitEdges(50);
    tripIn = 1; rampHold = 1;
    waitEdges(2);
    checkNow(4'b0000, "R9 trip over hold");
    tripIn = 0; rampHold = 0;
    waitEdges(5);
    checkNow(4'b0000, "R8 fault persists");
    supplyAboveOn = 0; supplyBelowOff = 1;
    waitEdges(3);
    supplyBelowOff = 0; supplyAboveOn = 1;
    waitEdges(5);
    checkNow(4'b0011, "R8 restart precharge");
    monOn = 0;

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R9: %0d runs left, expected 0", expQ.size());
    end
    checks++;
    if (legBad != 0) begin
      fails++;
      $display("FAIL R10: %0d leg overlaps, expected 0", legBad);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule